// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding

This block sits between a processor core and a write-back cache and holds stores that the core has issued but memory has not yet taken. A store is accepted at once and completes to the core. It stays speculative until the core retires it. Only retired stores leave the queue, one per handshake on the memory write port and always oldest first. A speculative flush drops every store not yet retired and keeps the retired ones.

Loads do not wait behind buffered stores. A load whose word has no overlapping buffered store goes straight to the cache. A load that overlaps buffered stores is served from the youngest overlapping store. If that store does not supply every byte the load requests, the load is held until that store has drained. A fence command fixes the order of later traffic against the stores already in the queue. A load fence holds loads, a store fence holds new stores, and a full fence holds both. Locked and serializing operations use the full fence.

Top module: `ordered_store_queue`

## Requirements
- R1: After a synchronous active-high reset the queue is empty: `st_ready` is 1 and `st_full`, `mem_valid`, `fence_busy`, `ld_hit` and `ld_stall` are 0.
- R2: A store is accepted on a cycle where `st_valid` and `st_ready` are both 1. When DEPTH entries are occupied, `st_full` is 1 and `st_ready` is 0. A store offered while `st_ready` is 0 is ignored.
- R3: `mem_valid` is 1 only while the oldest entry has been retired. A `ret_valid` pulse marks the oldest unretired entry as retired. The pulse is ignored when no unretired entry exists.
- R4: Entries drain in allocation order, one per cycle in which both `mem_valid` and `mem_ready` are 1. While `mem_ready` is 0, `mem_addr`, `mem_data` and `mem_be` hold steady.
- R5: `flush_spec` removes every unretired entry within one cycle and keeps all retired ones. A store offered in the same cycle is discarded. A retire pulse in the same cycle is applied before the flush.
- R6: A load overlaps a store when the word addresses are equal and their byte enables share at least one set bit. A load that overlaps no buffered store, with no load fence active, gives `ld_hit`=0 and `ld_stall`=0, and the load then reads the cache.
- R7: When the youngest overlapping store sets every byte that the load requests, `ld_hit` is 1. `ld_data` then carries that store's bytes in the requested lanes and zero in the other lanes. Byte lane b is bits 8b+7..8b and is enabled by bit b.
- R8: When the youngest overlapping store leaves some requested byte unset, `ld_stall` is 1 and `ld_hit` is 0 until that store has drained.
- R9: A store fence (`fence_kind`=2'b10) drops `st_ready` until every entry present when the fence was issued has drained. Loads are not affected.
- R10: A load fence (`fence_kind`=2'b01) raises `ld_stall` for every load until every entry present when the fence was issued has drained. Stores are still accepted.
- R11: A full fence (`fence_kind`=2'b11) holds both loads and stores. `fence_busy` is 1 while any fence is pending. A fence command (`fence_kind` nonzero) is ignored while `fence_busy` is 1. A fence issued when no older entry remains takes no effect. Code 2'b00 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_full | output | 1 | All entries occupied |
| ret_valid | input | 1 | Retire the oldest unretired store |
| flush_spec | input | 1 | Discard all unretired stores |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load word address |
| ld_be | input | DATA_W/8 | Load byte enables |
| ld_hit | output | 1 | Load served from the queue |
| ld_stall | output | 1 | Load must wait |
| ld_data | output | DATA_W | Forwarded data, unrequested lanes zero |
| fence_valid | input | 1 | Fence command |
| fence_kind | input | 2 | 01 load, 10 store, 11 full |
| fence_busy | output | 1 | A fence is pending |
| mem_valid | output | 1 | Oldest retired store offered to memory |
| mem_ready | input | 1 | Memory takes the offered store |
| mem_addr | output | ADDR_W | Drain word address |
| mem_data | output | DATA_W | Drain data |
| mem_be | output | DATA_W/8 | Drain byte enables |

## Verification
Some events are hard to bring about together: a flush, a retire and a drain in one cycle while a fence is counting down, with a load whose youngest overlapping store covers only part of its bytes. The bench builds a queue of four entries and uses only four word addresses. Byte enables are drawn from whole-word, half-word and single-byte patterns, so overlaps and partial covers happen often. A long pseudo-random sweep with rare flushes and fences and an irregular `mem_ready` then reaches those overlaps, and a cycle-level model computes every output.

// File: rtl/osq_pkg.sv
package osq_pkg;
  // bit 0 holds loads, bit 1 holds stores
  typedef enum logic [1:0] {
    FENCE_NONE  = 2'b00,
    FENCE_LOAD  = 2'b01,
    FENCE_STORE = 2'b10,
    FENCE_FULL  = 2'b11
  } fence_kind_e;
endpackage

// File: rtl/osq_occupancy.sv
module osq_occupancy #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             retire_req,
  input  logic             drain,
  input  logic             flush,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] ret_cnt,
  output logic [CNT_W-1:0] ret_next
);
  localparam int SW = CNT_W + PTR_W + 1;

  function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p,
                                               input logic [CNT_W-1:0] n);
    logic [SW-1:0] s;
    s = SW'(p) + SW'(n);
    if (s >= SW'(DEPTH)) s = s - SW'(DEPTH);
    return s[PTR_W-1:0];
  endfunction

  logic             ret_do;
  logic [PTR_W-1:0] head_nxt;

  assign ret_do   = retire_req && (ret_cnt < count);
  assign ret_next = ret_cnt + CNT_W'(ret_do) - CNT_W'(drain);
  assign head_nxt = drain ? ptr_add(head, CNT_W'(1)) : head;

  always_ff @(posedge clk) begin
    if (rst) begin
      head    <= '0;
      tail    <= '0;
      count   <= '0;
      ret_cnt <= '0;
    end else begin
      head    <= head_nxt;
      ret_cnt <= ret_next;
      if (flush) begin
        count <= ret_next;
        tail  <= ptr_add(head_nxt, ret_next);
      end else begin
        count <= count + CNT_W'(alloc) - CNT_W'(drain);
        if (alloc) tail <= ptr_add(tail, CNT_W'(1));
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R2
  AST_RET_WITHIN: assert property (@(posedge clk) disable iff (rst)
    ret_cnt <= count); // R3
  AST_FLUSH_KEEPS_RETIRED: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == ret_cnt)); // R5
endmodule

// File: rtl/osq_fence.sv
module osq_fence
  import osq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fence_valid,
  input  fence_kind_e      fence_kind,
  input  logic [CNT_W-1:0] count,
  input  logic             drain,
  input  logic             flush,
  input  logic [CNT_W-1:0] ret_next,
  output logic             fence_busy,
  output logic             blk_ld,
  output logic             blk_st
);
  fence_kind_e      kind_q;
  logic             active_q;
  logic [CNT_W-1:0] left_q, left_d;

  always_comb begin
    if (active_q) begin
      left_d = left_q - CNT_W'(drain);
      if (flush && (ret_next < left_d)) left_d = ret_next;
    end else begin
      left_d = flush ? ret_next : (count - CNT_W'(drain));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      left_q   <= '0;
      kind_q   <= FENCE_NONE;
    end else if (active_q) begin
      left_q   <= left_d;
      active_q <= (left_d != '0);
    end else if (fence_valid && (fence_kind != FENCE_NONE)) begin
      kind_q   <= fence_kind;
      left_q   <= left_d;
      active_q <= (left_d != '0);
    end
  end

  assign fence_busy = active_q;
  assign blk_ld = active_q && ((kind_q == FENCE_LOAD) || (kind_q == FENCE_FULL));
  assign blk_st = active_q && ((kind_q == FENCE_STORE) || (kind_q == FENCE_FULL));

  AST_FENCE_STORE_HOLD: assert property (@(posedge clk) disable iff (rst)
    blk_st |=> (count <= $past(count))); // R9
  AST_FENCE_DRAINS_OUT: assert property (@(posedge clk) disable iff (rst)
    (active_q && (count == '0)) |=> !active_q); // R11
endmodule

// File: rtl/osq_forward.sv
module osq_forward #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [ADDR_W-1:0] e_addr [DEPTH],
  input  logic [DATA_W-1:0] e_data [DEPTH],
  input  logic [BE_W-1:0]   e_be   [DEPTH],
  input  logic [PTR_W-1:0]  head,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BE_W-1:0]   ld_be,
  output logic              found,
  output logic              covered,
  output logic [DATA_W-1:0] fwd_data
);
  logic [PTR_W-1:0] sel;
  logic [PTR_W-1:0] slot;
  int               pos;

  // scan oldest to youngest; the last overlap seen is the youngest
  always_comb begin
    found = 1'b0;
    sel   = '0;
    slot  = '0;
    pos   = 0;
    for (int i = 0; i < DEPTH; i++) begin
      pos = int'(head) + i;
      if (pos >= DEPTH) pos = pos - DEPTH;
      slot = PTR_W'(pos);
      if ((i < int'(count)) && (e_addr[slot] == ld_addr) && ((e_be[slot] & ld_be) != '0)) begin
        found = 1'b1;
        sel   = slot;
      end
    end
  end

  assign covered = found && ((ld_be & ~e_be[sel]) == '0);

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign fwd_data[b*8 +: 8] = ld_be[b] ? e_data[sel][b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/ordered_store_queue.sv
module ordered_store_queue
  import osq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  output logic              st_ready,
  output logic              st_full,
  input  logic              ret_valid,
  input  logic              flush_spec,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BE_W-1:0]   ld_be,
  output logic              ld_hit,
  output logic              ld_stall,
  output logic [DATA_W-1:0] ld_data,
  input  logic              fence_valid,
  input  logic [1:0]        fence_kind,
  output logic              fence_busy,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BE_W-1:0]   mem_be
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [BE_W-1:0]   ent_be   [DEPTH];

  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count, ret_cnt, ret_next;
  logic             alloc, drain, blk_ld, blk_st;
  logic             fwd_found, fwd_cover;

  assign st_full   = (count == CNT_W'(DEPTH));
  assign st_ready  = !st_full && !blk_st;
  assign alloc     = st_valid && st_ready && !flush_spec;
  assign mem_valid = (ret_cnt != '0);
  assign drain     = mem_valid && mem_ready;

  osq_occupancy #(.DEPTH(DEPTH)) occ_i (
    .clk(clk), .rst(rst), .alloc(alloc), .retire_req(ret_valid),
    .drain(drain), .flush(flush_spec), .head(head), .tail(tail),
    .count(count), .ret_cnt(ret_cnt), .ret_next(ret_next)
  );

  osq_fence #(.DEPTH(DEPTH)) fence_i (
    .clk(clk), .rst(rst), .fence_valid(fence_valid),
    .fence_kind(fence_kind_e'(fence_kind)), .count(count), .drain(drain),
    .flush(flush_spec), .ret_next(ret_next), .fence_busy(fence_busy),
    .blk_ld(blk_ld), .blk_st(blk_st)
  );

  // entry storage: written only at the tail slot
  always_ff @(posedge clk) begin
    if (alloc) begin
      ent_addr[tail] <= st_addr;
      ent_data[tail] <= st_data;
      ent_be[tail]   <= st_be;
    end
  end

  assign mem_addr = ent_addr[head];
  assign mem_data = ent_data[head];
  assign mem_be   = ent_be[head];

  osq_forward #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) fwd_i (
    .e_addr(ent_addr), .e_data(ent_data), .e_be(ent_be), .head(head),
    .count(count), .ld_addr(ld_addr), .ld_be(ld_be), .found(fwd_found),
    .covered(fwd_cover), .fwd_data(ld_data)
  );

  assign ld_stall = ld_valid && (blk_ld || (fwd_found && !fwd_cover));
  assign ld_hit   = ld_valid && !blk_ld && fwd_cover;

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_data) && $stable(mem_be))); // R4
  AST_LD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ld_hit && ld_stall)); // R8
  AST_FULL_NO_READY: assert property (@(posedge clk) disable iff (rst)
    st_full |-> !st_ready); // R2
endmodule

// File: tb/ordered_store_queue_tb_top.sv
`timescale 1ns/1ps
module ordered_store_queue_tb_top;
  localparam int D = 4, AW = 4, DW = 32, BW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic st_valid, st_ready, st_full, ret_valid, flush_spec;
  logic [AW-1:0] st_addr, ld_addr, mem_addr;
  logic [DW-1:0] st_data, ld_data, mem_data;
  logic [BW-1:0] st_be, ld_be, mem_be;
  logic ld_valid, ld_hit, ld_stall, fence_valid, fence_busy, mem_valid, mem_ready;
  logic [1:0] fence_kind;

  ordered_store_queue #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_be(st_be), .st_ready(st_ready), .st_full(st_full), .ret_valid(ret_valid),
    .flush_spec(flush_spec), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be),
    .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_data(ld_data), .fence_valid(fence_valid),
    .fence_kind(fence_kind), .fence_busy(fence_busy), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model: index 0 is the oldest entry
  logic [AW-1:0] ma [D];
  logic [DW-1:0] md [D];
  logic [BW-1:0] mb [D];
  int mcnt, mret, fleft;
  bit fact;
  logic [1:0] fkind;

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, a, e, $time);
    end
  endtask

  function automatic logic [DW-1:0] lane_mask(input logic [BW-1:0] be);
    logic [DW-1:0] m = '0;
    for (int b = 0; b < BW; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic idle();
    st_valid = 0; st_addr = '0; st_data = '0; st_be = '0;
    ret_valid = 0; flush_spec = 0; ld_valid = 0; ld_addr = '0; ld_be = '0;
    fence_valid = 0; fence_kind = 2'b00; mem_ready = 0;
  endtask

  task automatic check_now();
    bit fl, fs, found, cov, e_st, e_hit;
    int sel;
    string lt;
    fl = fact && fkind[0];
    fs = fact && fkind[1];
    chk(fs ? "R9" : "R2", st_ready, (mcnt < D) && !fs);
    chk("R2", st_full, mcnt == D);
    chk("R3", mem_valid, mret > 0);
    if (mret > 0) begin
      chk("R4", mem_addr, ma[0]);
      chk("R4", mem_data, md[0]);
      chk("R4", mem_be, mb[0]);
    end
    chk("R11", fence_busy, fact);
    found = 0; sel = 0;
    for (int i = 0; i < mcnt; i++)
      if (ma[i] == ld_addr && (mb[i] & ld_be) != 0) begin found = 1; sel = i; end
    cov = found && ((ld_be & ~mb[sel]) == 0);
    if (fl) lt = (fkind == 2'b11) ? "R11" : "R10";
    else if (!found) lt = "R6";
    else lt = cov ? "R7" : "R8";
    e_st  = ld_valid && (fl || (found && !cov));
    e_hit = ld_valid && !fl && cov;
    chk(lt, ld_stall, e_st);
    chk(lt, ld_hit, e_hit);
    if (e_hit) chk("R7", ld_data, md[sel] & lane_mask(ld_be));
  endtask

  task automatic model_update();
    bit drn, rdo, fs, alc;
    int nret, ocnt;
    drn  = (mret > 0) && mem_ready;
    rdo  = ret_valid && (mret < mcnt);
    fs   = fact && fkind[1];
    alc  = st_valid && (mcnt < D) && !fs && !flush_spec;
    nret = mret + int'(rdo) - int'(drn);
    ocnt = mcnt;
    if (drn) begin
      for (int i = 0; i < D - 1; i++) begin ma[i] = ma[i+1]; md[i] = md[i+1]; mb[i] = mb[i+1]; end
      mcnt--;
    end
    if (flush_spec) mcnt = nret;
    else if (alc) begin ma[mcnt] = st_addr; md[mcnt] = st_data; mb[mcnt] = st_be; mcnt++; end
    mret = nret;
    if (fact) begin
      fleft -= int'(drn);
      if (flush_spec && nret < fleft) fleft = nret;
      if (fleft == 0) fact = 0;
    end else if (fence_valid && fence_kind != 2'b00) begin
      fleft = flush_spec ? nret : ocnt - int'(drn);
      fkind = fence_kind;
      fact  = (fleft != 0);
    end
  endtask

  task automatic tick();
    #1;
    check_now();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  function automatic logic [BW-1:0] pick_be(input int k);
    case (k % 6)
      0: return 4'hF;
      1: return 4'h3;
      2: return 4'hC;
      3: return 4'h1;
      4: return 4'h2;
      default: return 4'h6;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    idle();
    rst = 1;
    mcnt = 0; mret = 0; fleft = 0; fact = 0; fkind = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1", st_ready, 1); chk("R1", st_full, 0); chk("R1", mem_valid, 0);
    chk("R1", fence_busy, 0); chk("R1", ld_hit, 0); chk("R1", ld_stall, 0);
    @(negedge clk);

    // R2/R3: fill with unretired stores while memory is ready; nothing drains
    for (int i = 0; i < D + 1; i++) begin
      idle(); mem_ready = 1;
      st_valid = 1; st_addr = AW'(i % 3); st_data = 32'hA0A0_0000 + i; st_be = 4'hF;
      ld_valid = 1; ld_addr = '0; ld_be = 4'h3;
      tick();
    end
    // R7/R8: lookups against a full queue
    idle(); ld_valid = 1; ld_addr = 4'd1; ld_be = 4'hF; tick();
    idle(); ld_valid = 1; ld_addr = 4'd3; ld_be = 4'hF; tick();
    // R3/R4: retire two, memory stalls, then drain
    idle(); ret_valid = 1; tick(); tick();
    idle(); tick(); tick();
    idle(); mem_ready = 1; tick(); tick(); tick();
    // R5: one retired and two speculative, then flush
    idle(); ret_valid = 1; mem_ready = 1;
    for (int i = 0; i < 8; i++) tick();
    for (int i = 0; i < 3; i++) begin
      idle(); st_valid = 1; st_addr = AW'(i); st_data = 32'h5000 + i; st_be = 4'hF; tick();
    end
    idle(); ret_valid = 1; tick();
    idle(); flush_spec = 1; st_valid = 1; st_addr = 4'd9; st_be = 4'hF; tick();
    n = 0;
    for (int i = 0; i < 6; i++) begin
      idle(); mem_ready = 1; #1; if (mem_valid) n++; tick();
    end
    chk("R5", n, 1);
    // R9/R10/R11: each fence kind behind two retired stores
    for (int k = 1; k < 4; k++) begin
      for (int i = 0; i < 2; i++) begin
        idle(); st_valid = 1; st_addr = AW'(i); st_data = 32'h7700 + k * 16 + i;
        st_be = 4'hF; ret_valid = 1; tick();
      end
      idle(); ret_valid = 1; tick();
      idle(); fence_valid = 1; fence_kind = 2'(k); tick();
      idle(); fence_valid = 1; fence_kind = 2'b11; st_valid = 1; st_addr = 4'd7;
      st_be = 4'hF; ld_valid = 1; ld_addr = 4'd5; ld_be = 4'hF; tick();
      for (int i = 0; i < 4; i++) begin
        idle(); mem_ready = 1; ret_valid = 1; ld_valid = 1; ld_addr = 4'd0; ld_be = 4'hF;
        st_valid = 1; st_addr = 4'd8; st_be = 4'h1; tick();
      end
      idle(); ret_valid = 1; mem_ready = 1;
      for (int i = 0; i < 6; i++) tick();
    end
    // R11: fence on an empty queue
    idle(); fence_valid = 1; fence_kind = 2'b11; tick();
    idle(); tick();

    // sweep: tight address space, mixed byte enables, irregular memory
    for (int c = 0; c < 6000; c++) begin
      logic [31:0] r;
      r = $urandom;
      idle();
      st_valid    = r[0] | r[1];
      st_addr     = AW'($urandom_range(0, 3));
      st_data     = $urandom;
      st_be       = pick_be($urandom_range(0, 5));
      ret_valid   = r[2] & (r[3] | r[4]);
      flush_spec  = ($urandom_range(0, 39) == 0);
      ld_valid    = r[5] | r[6];
      ld_addr     = AW'($urandom_range(0, 3));
      ld_be       = pick_be($urandom_range(0, 5));
      fence_valid = ($urandom_range(0, 24) == 0);
      fence_kind  = r[9:8];
      mem_ready   = r[10] & (r[11] | r[12]);
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule